// File: doc/BRIEF.md
# Status Flags and Deferred ALU Function Register

This block keeps the processor's condition flags (carry, zero, negative, overflow) together with a 4-bit ALU function code in one 12-bit status word. An ALU instruction either runs at once on a chosen source register (direct form) or, with its source field set to the lock code, parks its function code in the register. In the lock case the next instruction that writes the accumulator runs through the ALU with that function. The parked code goes back to pass-through when that following instruction ends, whether or not it wrote the accumulator.

The decoder drives one-cycle strobes: an ALU instruction, an accumulator write, a register result write, a memory write, and an end-of-instruction pulse. The ALU returns its flag outputs. The register presents the function the ALU must apply in each cycle. For a stack push it exposes the whole status word, and for a pop it reloads from a stack word. Individual flags can be forced set or clear.

Top module: `alu_status_reg`

## Requirements
- R1: `stk_word_o` packs the state as bits 3..0 = function code, bit 4 = V, bit 5 = N, bit 6 = Z, bit 7 = C, and bits 11..8 always zero. `flags_o` and `flags_in_i` use the order [3]=C, [2]=Z, [1]=N, [0]=V.
- R2: While `rst_ni` is low, the function field and all flags are zero. After reset, `alu_func_o` shows pass-through (0000) for an accumulator write.
- R3: An ALU strobe with source code 11 writes `alu_func_i` into the function field at the next clock edge. It shows pass-through on `alu_func_o` in that cycle and updates no flag unless `res_wr_i` is also set.
- R4: While a function is held, `alu_func_o` equals it only in cycles with `acc_wr_i` high. Any other cycle with no ALU strobe shows 0000.
- R5: A held function survives the end of the instruction that latched it. It is cleared to 0000 by the next end-of-instruction pulse, even if no accumulator write happened in between.
- R6: An ALU strobe with source code 00, 01 or 10 (direct form) puts `alu_func_i` on `alu_func_o` in that cycle only and does not change the stored function field.
- R7: `res_wr_i` loads the flags from `flags_in_i`, except for a direct-form ALU strobe with function 0000, which leaves the flags unchanged.
- R8: A cycle with `mem_wr_i` high loads no flag from `flags_in_i`, even if `res_wr_i` is high.
- R9: `flag_set_i` and `flag_clr_i` force single flags after any load in the same cycle. Clear wins over set.
- R10: `pop_i` loads bits 7..0 of the status from `pop_word_i` and ignores its bits 11..8. It overrides the lock, the flag load and the set/clear inputs of that cycle. A popped non-zero function is kept until the end of the instruction that follows the pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alu_op_i | input | 1 | ALU instruction strobe |
| alu_src_i | input | 2 | ALU source field; 11 = lock |
| alu_func_i | input | 4 | ALU function field of the instruction |
| acc_wr_i | input | 1 | Accumulator is written this cycle |
| res_wr_i | input | 1 | A register result is written; flags may load |
| mem_wr_i | input | 1 | Memory write cycle; blocks flag load |
| flags_in_i | input | 4 | Flags from the ALU {C,Z,N,V} |
| flag_set_i | input | 4 | Force flags set {C,Z,N,V} |
| flag_clr_i | input | 4 | Force flags clear {C,Z,N,V} |
| instr_end_i | input | 1 | End-of-instruction pulse |
| pop_i | input | 1 | Load status from stack word |
| pop_word_i | input | 12 | Stack word for pop |
| alu_func_o | output | 4 | Function the ALU applies this cycle |
| flags_o | output | 4 | Current flags {C,Z,N,V} |
| stk_word_o | output | 12 | Status word for push |

## Verification
If the lock state were wrong, the next accumulator write would show a wrong code on `alu_func_o` in that same cycle. The stale or missing function would also appear in `stk_word_o[3:0]` one edge after the end pulse that should have released it. A wrong flag state shows on `flags_o` and `stk_word_o[7:4]` one edge after the offending strobe. Because of this, every vector checks the combinational function mid-cycle and the packed word just after the edge.

// File: rtl/asr_pkg.sv
`timescale 1ns/1ps
package asr_pkg;
  localparam int FUNC_W  = 4;
  localparam int NFLAG   = 4;
  localparam int SRC_W   = 2;
  localparam logic [FUNC_W-1:0] FUNC_PASS = '0;
  localparam logic [SRC_W-1:0]  SRC_LOCK  = 2'b11;
  // flag vector index order
  localparam int FL_V = 0;
  localparam int FL_N = 1;
  localparam int FL_Z = 2;
  localparam int FL_C = 3;
endpackage

// File: rtl/asr_func_ctl.sv
`timescale 1ns/1ps
module asr_func_ctl #(
  parameter int FUNC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              direct_i,
  input  logic [FUNC_W-1:0] ins_func_i,
  input  logic              acc_wr_i,
  input  logic              instr_end_i,
  input  logic              pop_i,
  input  logic [FUNC_W-1:0] pop_func_i,
  output logic [FUNC_W-1:0] func_q_o,
  output logic [FUNC_W-1:0] alu_func_o
);
  localparam logic [FUNC_W-1:0] PASS = '0;

  logic [FUNC_W-1:0] func_q;
  logic              hold_q;   // function loaded inside the current instruction
  logic              load_now;

  assign load_now = pop_i ? (pop_func_i != PASS) : lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      func_q <= PASS;
      hold_q <= 1'b0;
    end else begin
      if (pop_i)                      func_q <= pop_func_i;
      else if (lock_i)                func_q <= ins_func_i;
      else if (instr_end_i && !hold_q) func_q <= PASS;

      if (instr_end_i)   hold_q <= 1'b0;
      else if (load_now) hold_q <= 1'b1;
    end
  end

  always_comb begin
    if (direct_i)      alu_func_o = ins_func_i;
    else if (acc_wr_i) alu_func_o = func_q;
    else               alu_func_o = PASS;
  end

  assign func_q_o = func_q;

  AST_LOCK_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i && !pop_i |=> func_q == $past(ins_func_i)); // R3

  AST_LOCK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_end_i && !hold_q && !lock_i && !pop_i |=> func_q == PASS); // R5

  AST_DIRECT_NOT_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_i && !pop_i && !instr_end_i |=> $stable(func_q)); // R6

  AST_POP_FUNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> func_q == $past(pop_func_i)); // R10
endmodule

// File: rtl/asr_flag_store.sv
`timescale 1ns/1ps
module asr_flag_store #(
  parameter int NFLAG = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [NFLAG-1:0] flags_in_i,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic             pop_i,
  input  logic [NFLAG-1:0] pop_flags_i,
  output logic [NFLAG-1:0] flags_o
);
  logic [NFLAG-1:0] flags_q;
  logic [NFLAG-1:0] loaded;
  logic [NFLAG-1:0] flags_d;

  assign loaded = upd_i ? flags_in_i : flags_q;

  always_comb begin
    if (pop_i) flags_d = pop_flags_i;
    else       flags_d = (loaded | set_i) & ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  AST_POP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> flags_o == $past(pop_flags_i)); // R10

  AST_FLAGS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i && !pop_i && set_i == '0 && clr_i == '0 |=> $stable(flags_o)); // R8

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i && clr_i != '0 |=> (flags_o & $past(clr_i)) == '0); // R9

  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |=> (flags_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)); // R9
endmodule

// File: rtl/alu_status_reg.sv
`timescale 1ns/1ps
module alu_status_reg
  import asr_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alu_op_i,
  input  logic [SRC_W-1:0]  alu_src_i,
  input  logic [FUNC_W-1:0] alu_func_i,
  input  logic              acc_wr_i,
  input  logic              res_wr_i,
  input  logic              mem_wr_i,
  input  logic [NFLAG-1:0]  flags_in_i,
  input  logic [NFLAG-1:0]  flag_set_i,
  input  logic [NFLAG-1:0]  flag_clr_i,
  input  logic              instr_end_i,
  input  logic              pop_i,
  input  logic [WORD_W-1:0] pop_word_i,
  output logic [FUNC_W-1:0] alu_func_o,
  output logic [NFLAG-1:0]  flags_o,
  output logic [WORD_W-1:0] stk_word_o
);
  localparam int USED_W = FUNC_W + NFLAG;

  logic              is_lock;
  logic              is_direct;
  logic              flag_upd;
  logic [FUNC_W-1:0] func_q;
  logic [NFLAG-1:0]  pop_flags;
  logic              unused_pop_hi;

  assign is_lock   = alu_op_i && (alu_src_i == SRC_LOCK);
  assign is_direct = alu_op_i && (alu_src_i != SRC_LOCK);
  // direct pass-through is the one register write that keeps flags
  assign flag_upd  = res_wr_i && !mem_wr_i && !(is_direct && alu_func_i == FUNC_PASS);

  assign pop_flags     = pop_word_i[USED_W-1:FUNC_W];
  assign unused_pop_hi = ^pop_word_i[WORD_W-1:USED_W];

  asr_func_ctl #(.FUNC_W(FUNC_W)) u_func (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_i      (is_lock),
    .direct_i    (is_direct),
    .ins_func_i  (alu_func_i),
    .acc_wr_i    (acc_wr_i),
    .instr_end_i (instr_end_i),
    .pop_i       (pop_i),
    .pop_func_i  (pop_word_i[FUNC_W-1:0]),
    .func_q_o    (func_q),
    .alu_func_o  (alu_func_o)
  );

  asr_flag_store #(.NFLAG(NFLAG)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_i       (flag_upd),
    .flags_in_i  (flags_in_i),
    .set_i       (flag_set_i),
    .clr_i       (flag_clr_i),
    .pop_i       (pop_i),
    .pop_flags_i (pop_flags),
    .flags_o     (flags_o)
  );

  assign stk_word_o[FUNC_W-1:0] = func_q;
  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag_bits
    assign stk_word_o[FUNC_W+gi] = flags_o[gi];
  end
  for (genvar gj = USED_W; gj < WORD_W; gj++) begin : g_pad_bits
    assign stk_word_o[gj] = 1'b0;
  end

  AST_MEM_WR_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_i && !pop_i && flag_set_i == '0 && flag_clr_i == '0 |=> $stable(flags_o)); // R8

  AST_PASS_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_direct && alu_func_i == FUNC_PASS && !pop_i && flag_set_i == '0 && flag_clr_i == '0
    |=> $stable(flags_o)); // R7

  AST_RES_LOADS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_upd && !pop_i && flag_set_i == '0 && flag_clr_i == '0
    |=> flags_o == $past(flags_in_i)); // R7

  AST_IDLE_FUNC_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alu_op_i && !acc_wr_i |-> alu_func_o == FUNC_PASS); // R4
endmodule

// File: tb/alu_status_reg_tb_top.sv
`timescale 1ns/1ps
module alu_status_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alu_op, acc_wr, res_wr, mem_wr, iend, pop;
  logic [1:0]  src;
  logic [3:0]  fn, fin, fset, fclr;
  logic [11:0] pw;
  logic [3:0]  func_o, flags_o;
  logic [11:0] word_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  alu_status_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .alu_op_i(alu_op), .alu_src_i(src),
    .alu_func_i(fn), .acc_wr_i(acc_wr), .res_wr_i(res_wr), .mem_wr_i(mem_wr),
    .flags_in_i(fin), .flag_set_i(fset), .flag_clr_i(fclr), .instr_end_i(iend),
    .pop_i(pop), .pop_word_i(pw), .alu_func_o(func_o), .flags_o(flags_o),
    .stk_word_o(word_o)
  );

  typedef struct packed {
    logic        op;  logic [1:0] src; logic [3:0] fn;
    logic        acc; logic res; logic mem;
    logic [3:0]  fin; logic [3:0] set; logic [3:0] clr;
    logic        pop; logic [11:0] pw; logic iend;
    logic [3:0]  efn; logic [11:0] ew; logic [7:0] rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0,2'b00,4'h0,1'b1,1'b1,1'b0,4'b0100,4'h0,4'h0,1'b0,12'h000,1'b1,4'h0,12'h040,8'd7},  // transfer -> Z
    '{1'b1,2'b01,4'h3,1'b1,1'b1,1'b0,4'b1000,4'h0,4'h0,1'b0,12'h000,1'b1,4'h3,12'h080,8'd6},  // direct, not stored
    '{1'b1,2'b00,4'h0,1'b1,1'b1,1'b0,4'b0010,4'h0,4'h0,1'b0,12'h000,1'b1,4'h0,12'h080,8'd7},  // direct pass keeps flags
    '{1'b1,2'b11,4'h5,1'b0,1'b0,1'b0,4'b0000,4'h0,4'h0,1'b0,12'h000,1'b1,4'h0,12'h085,8'd3},  // lock, one-cycle instr
    '{1'b0,2'b00,4'h0,1'b1,1'b1,1'b0,4'b0001,4'h0,4'h0,1'b0,12'h000,1'b0,4'h5,12'h015,8'd4},  // acc write uses lock
    '{1'b0,2'b00,4'h0,1'b0,1'b0,1'b0,4'b0000,4'h0,4'h0,1'b0,12'h000,1'b1,4'h0,12'h010,8'd5},  // released
    '{1'b1,2'b11,4'h9,1'b0,1'b0,1'b0,4'b0000,4'h0,4'h0,1'b0,12'h000,1'b0,4'h0,12'h019,8'd3},  // lock, multi-cycle
    '{1'b0,2'b00,4'h0,1'b0,1'b0,1'b0,4'b0000,4'h0,4'h0,1'b0,12'h000,1'b1,4'h0,12'h019,8'd5},  // survives own end
    '{1'b0,2'b00,4'h0,1'b0,1'b1,1'b0,4'b0100,4'h0,4'h0,1'b0,12'h000,1'b0,4'h0,12'h049,8'd4},  // non-acc write: pass
    '{1'b0,2'b00,4'h0,1'b0,1'b0,1'b0,4'b0000,4'h0,4'h0,1'b0,12'h000,1'b1,4'h0,12'h040,8'd5},  // lost, cleared
    '{1'b0,2'b00,4'h0,1'b0,1'b1,1'b1,4'b1111,4'h0,4'h0,1'b0,12'h000,1'b1,4'h0,12'h040,8'd8},  // mem write blocks
    '{1'b0,2'b00,4'h0,1'b0,1'b0,1'b0,4'b0000,4'h9,4'h0,1'b0,12'h000,1'b0,4'h0,12'h0D0,8'd9},  // set C,V
    '{1'b0,2'b00,4'h0,1'b0,1'b1,1'b0,4'b0010,4'h4,4'h4,1'b0,12'h000,1'b0,4'h0,12'h020,8'd9},  // clr wins
    '{1'b0,2'b00,4'h0,1'b0,1'b1,1'b0,4'b1111,4'h1,4'h0,1'b1,12'hFA3,1'b0,4'h0,12'h0A3,8'd10}, // pop overrides
    '{1'b0,2'b00,4'h0,1'b0,1'b0,1'b0,4'b0000,4'h0,4'h0,1'b0,12'h000,1'b1,4'h0,12'h0A3,8'd10}, // popped func kept
    '{1'b0,2'b00,4'h0,1'b0,1'b0,1'b0,4'b0000,4'h0,4'h0,1'b0,12'h000,1'b1,4'h0,12'h0A0,8'd10}, // then released
    '{1'b1,2'b11,4'h6,1'b0,1'b0,1'b0,4'b0000,4'h0,4'h0,1'b0,12'h000,1'b0,4'h0,12'h0A6,8'd3},  // lock again
    '{1'b0,2'b00,4'h0,1'b0,1'b0,1'b0,4'b0000,4'h0,4'h0,1'b1,12'h0F0,1'b1,4'h0,12'h0F0,8'd10}  // pop zero func
  };

  task automatic idle();
    alu_op = 0; src = 0; fn = 0; acc_wr = 0; res_wr = 0; mem_wr = 0;
    fin = 0; fset = 0; fclr = 0; iend = 0; pop = 0; pw = 0;
  endtask

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %03h expected %03h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R2 reset word", word_o, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    acc_wr = 1; #1;
    chk("R2 func after reset", {8'h0, func_o}, 12'h000);
    idle();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      alu_op = VECS[i].op;  src = VECS[i].src;  fn = VECS[i].fn;
      acc_wr = VECS[i].acc; res_wr = VECS[i].res; mem_wr = VECS[i].mem;
      fin = VECS[i].fin; fset = VECS[i].set; fclr = VECS[i].clr;
      pop = VECS[i].pop; pw = VECS[i].pw; iend = VECS[i].iend;
      #1;
      chk($sformatf("R%0d vec %0d alu_func_o", VECS[i].rq, i), {8'h0, func_o}, {8'h0, VECS[i].efn});
      @(posedge clk); #1;
      chk($sformatf("R%0d vec %0d stk_word_o", VECS[i].rq, i), word_o, VECS[i].ew);
      chk($sformatf("R1 vec %0d flags_o vs word", i), {8'h0, flags_o}, {8'h0, VECS[i].ew[7:4]});
    end

    // R2: asynchronous reset during a pending lock
    @(negedge clk); idle();
    alu_op = 1; src = 2'b11; fn = 4'hC;
    @(negedge clk); idle();
    chk("R3 lock pending", word_o, 12'h0FC);
    rst_n = 1'b0; #1;
    chk("R2 async clear", word_o, 12'h000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    acc_wr = 1; #1;
    chk("R2 lock lost after reset", {8'h0, func_o}, 12'h000);
    idle();

    // R6: direct form with end pulse absent leaves stored field at zero
    @(negedge clk);
    alu_op = 1; src = 2'b10; fn = 4'h7; #1;
    chk("R6 direct drives func", {8'h0, func_o}, 12'h007);
    @(posedge clk); #1;
    chk("R6 direct not stored", word_o, 12'h000);
    @(negedge clk); idle();
    finish_run();
  end
endmodule